// File: doc/BRIEF.md
# Horizontal Active-Pixel Capture Window

This block sits at the front of a scan converter. It watches a low-rate video stream that arrives as a serial pixel bit, a dot-clock enable, and horizontal and vertical sync. For every dot tick it decides whether that tick carries visible picture. It then issues a write strobe with a column and line position, so that a line or frame buffer can store the bit. The block runs in the system clock domain. The two syncs are treated as asynchronous and are resynchronised. The dot clock arrives as a one-cycle enable and is never used as a clock.

The visible span of a line is not a fixed count of pixels. It is bounded by dot-tick counts taken from the two sync edges of the line. Capture opens a set number of ticks after horizontal sync ends. It closes a set number of ticks after the next horizontal sync starts. Both counts are parameters, and an error of even two ticks moves the whole picture sideways. An optional scanline mode flags every odd line so that later logic can darken it.

The controller is a four-state machine:
- `ST_IDLE`: waits during sync and blanking.
- `ST_WAIT`: counts off the start delay.
- `ST_ACTIVE`: passes pixels through.
- `ST_TAIL`: passes the last tail-delay pixels after sync has started.

The transitions are:
- A sync end moves any state to `ST_WAIT`.
- `ST_WAIT` moves to `ST_ACTIVE` when its count runs out.
- `ST_WAIT` moves to `ST_IDLE` when sync starts early.
- `ST_ACTIVE` moves to `ST_TAIL` when sync starts.
- `ST_TAIL` moves to `ST_IDLE` when its count runs out. This transition also ends the line.

Top module: `hcap_window`

## Requirements
- R1: All delays advance only on clock cycles where `dot_en` is 1. Any number of system clock cycles without `dot_en` changes no count. A change on `hsync_in` takes effect from the third rising clock edge after it, through a two-flop synchroniser and an edge detector.
- R2: Sync is active high. After `hsync_in` falls, the first `START_DLY` dot ticks (default 9) are skipped. Tick number `START_DLY`+1 is the first valid pixel, and it carries column 0.
- R3: After `hsync_in` rises during capture, exactly `TAIL_DLY` further dot ticks (default 9) are valid pixels. No later tick of that line is valid.
- R4: Each valid pixel appears on `pix_valid` one clock after its tick. `pix_data` equals `vid_in` at that tick. `pix_col` rises by exactly one per valid pixel within a line.
- R5: `line_idx` rises by one when the last tail pixel of a line is taken. It is held at 0 while the synchronised `vsync_in` is high.
- R6: With `scan_mode` at 1, `pix_dim` is 1 on pixels of odd lines and 0 on pixels of even lines. With `scan_mode` at 0, `pix_dim` is always 0.
- R7: If `hsync_in` rises again before the start delay has run out, that line yields no valid pixel and `line_idx` does not change.
- R8: After reset, `pix_valid` is 0, `pix_col` is 0 and `line_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | One-cycle pulse per video dot |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| vid_in | input | 1 | Serial pixel bit, valid with `dot_en` |
| scan_mode | input | 1 | Enables odd-line dimming flag |
| pix_valid | output | 1 | Write strobe for one captured pixel |
| pix_data | output | 1 | Captured pixel bit |
| pix_col | output | COL_W | Column of the captured pixel |
| line_idx | output | LINE_W | Index of the line being captured |
| pix_dim | output | 1 | Pixel belongs to a line to be darkened |

## Verification
A sync change acts on dot ticks from the third clock edge after it. The bench therefore leaves four idle clocks after every sync change before it issues the next tick. A captured pixel, its column and its dim flag appear one clock after the tick that carries it. The bench drives each tick for one cycle and samples at the following falling edge. The line index changes on that same edge for the last tail pixel, so it is read right after that pixel. The vertical sync clear is read four clocks after the sync change.

// File: rtl/hcap_pkg.sv
package hcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACTIVE,
        ST_TAIL
    } hcap_state_e;
endpackage

// File: rtl/hcap_sync.sv
module hcap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hcap_edge.sv
module hcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/hcap_window.sv
module hcap_window
    import hcap_pkg::*;
#(
    parameter int START_DLY = 9,
    parameter int TAIL_DLY  = 9,
    parameter int COL_W     = 11,
    parameter int LINE_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              vid_in,
    input  logic              scan_mode,
    output logic              pix_valid,
    output logic              pix_data,
    output logic [COL_W-1:0]  pix_col,
    output logic [LINE_W-1:0] line_idx,
    output logic              pix_dim
);
    localparam int MAX_DLY = (START_DLY > TAIL_DLY) ? START_DLY : TAIL_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_DLY - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_DLY - 1);

    logic [1:0] sync_q;
    logic       hs_rise, hs_fall, vs_lvl;

    hcap_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vsync_in, hsync_in}),
        .q     (sync_q)
    );

    hcap_edge u_hs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_q[0]),
        .rise  (hs_rise),
        .fall  (hs_fall)
    );

    assign vs_lvl = sync_q[1];

    hcap_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              take, line_done;
    logic [COL_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        take      = 1'b0;
        line_done = 1'b0;
        if (hs_fall) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_WAIT: begin
                    if (hs_rise) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (dot_en) begin
                        if (cnt_q == START_LAST) begin
                            state_d = ST_ACTIVE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (hs_rise) begin
                        state_d = ST_TAIL;
                        cnt_d   = '0;
                    end else if (dot_en) begin
                        take = 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (dot_en) begin
                        take = 1'b1;
                        if (cnt_q == TAIL_LAST) begin
                            state_d   = ST_IDLE;
                            cnt_d     = '0;
                            line_done = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_data  <= 1'b0;
            pix_col   <= '0;
            pix_dim   <= 1'b0;
            col_q     <= '0;
            line_q    <= '0;
        end else begin
            pix_valid <= take;
            if (take) begin
                pix_data <= vid_in;
                pix_col  <= col_q;
                pix_dim  <= scan_mode & line_q[0];
            end
            if (hs_fall)   col_q <= '0;
            else if (take) col_q <= col_q + 1'b1;
            if (vs_lvl)         line_q <= '0;
            else if (line_done) line_q <= line_q + 1'b1;
        end
    end

    assign line_idx = line_q;

    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(dot_en));                                   // R1
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (cnt_q <= START_LAST));                // R2
    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> (cnt_q <= TAIL_LAST));                 // R3
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        vs_lvl |=> (line_idx == '0));                                   // R5
    AST_DIM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_dim) |-> $past(scan_mode));                   // R6
endmodule

// File: tb/hcap_window_tb.sv
`timescale 1ns/1ps
module hcap_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0, hsync_in = 1'b1, vsync_in = 1'b0;
    logic        vid_in = 1'b0, scan_mode = 1'b0;
    logic        pix_valid, pix_data, pix_dim;
    logic [10:0] pix_col;
    logic [9:0]  line_idx;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    int nvalid, first_tick, last_tick, last_col, bad_data, bad_col, dim_cnt;

    always #4 clk = ~clk;

    hcap_window dut_i (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .vid_in(vid_in), .scan_mode(scan_mode),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_col(pix_col),
        .line_idx(line_idx), .pix_dim(pix_dim)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_hs(input logic v);
        @(negedge clk);
        hsync_in = v;
        idle(4);
    endtask

    // one dot tick; records the pixel it produces
    task automatic tick(input int k);
        logic v;
        v = ((k * 5 + 1) % 3) == 0;
        @(negedge clk);
        dot_en = 1'b1;
        vid_in = v;
        @(negedge clk);
        dot_en = 1'b0;
        if (pix_valid) begin
            if (nvalid == 0) first_tick = k;
            if (pix_data !== v) bad_data++;
            if (int'(pix_col) != nvalid) bad_col++;
            if (pix_dim) dim_cnt++;
            last_tick = k;
            last_col  = int'(pix_col);
            nvalid++;
        end
        idle(2);
    endtask

    task automatic run_line(input int pre, input int post, input int gap);
        nvalid = 0; first_tick = -1; last_tick = -1; last_col = -1;
        bad_data = 0; bad_col = 0; dim_cnt = 0;
        set_hs(1'b0);
        idle(gap);
        for (int k = 1; k <= pre; k++) tick(k);
        set_hs(1'b1);
        for (int k = pre + 1; k <= pre + post; k++) tick(k);
    endtask

    task automatic test_reset();
        check(pix_valid == 1'b0, "R8 valid", int'(pix_valid), 0);
        check(pix_col == 0, "R8 col", int'(pix_col), 0);
        check(line_idx == 0, "R8 line", int'(line_idx), 0);
    endtask

    task automatic test_basic();
        run_line(30, 12, 0);
        check(first_tick == 10, "R2 first tick", first_tick, 10);
        check(last_tick == 39, "R3 last tick", last_tick, 39);
        check(nvalid == 30, "R3 count", nvalid, 30);
        check(last_col == 29, "R4 last col", last_col, 29);
        check(bad_data == 0, "R4 data", bad_data, 0);
        check(bad_col == 0, "R4 col step", bad_col, 0);
        check(line_idx == 1, "R5 line incr", int'(line_idx), 1);
    endtask

    task automatic test_gap();
        run_line(30, 12, 100);
        check(first_tick == 10, "R1 first tick after idle clocks", first_tick, 10);
        check(nvalid == 30, "R1 count", nvalid, 30);
        check(line_idx == 2, "R1 line", int'(line_idx), 2);
    endtask

    task automatic test_edge_min();
        run_line(10, 9, 0);
        check(first_tick == 10, "R2 min first", first_tick, 10);
        check(nvalid == 10, "R3 min count", nvalid, 10);
        check(last_col == 9, "R4 min last col", last_col, 9);
        check(line_idx == 3, "R5 min line", int'(line_idx), 3);
    endtask

    task automatic test_short();
        run_line(5, 12, 0);
        check(nvalid == 0, "R7 no pixels", nvalid, 0);
        check(line_idx == 3, "R7 line kept", int'(line_idx), 3);
    endtask

    task automatic test_vsync();
        @(negedge clk); vsync_in = 1'b1;
        idle(4);
        check(line_idx == 0, "R5 vsync clear", int'(line_idx), 0);
        @(negedge clk); vsync_in = 1'b0;
        idle(4);
    endtask

    task automatic test_scan();
        scan_mode = 1'b1;
        run_line(30, 12, 0);
        check(dim_cnt == 0, "R6 even line not dim", dim_cnt, 0);
        run_line(30, 12, 0);
        check(dim_cnt == 30, "R6 odd line dim", dim_cnt, 30);
        scan_mode = 1'b0;
        run_line(30, 12, 0);
        run_line(30, 12, 0);
        check(dim_cnt == 0, "R6 mode off", dim_cnt, 0);
        check(line_idx == 4, "R5 four lines", int'(line_idx), 4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        test_reset();
        test_basic();
        test_gap();
        test_edge_min();
        test_short();
        test_vsync();
        test_scan();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule